// File: doc/BRIEF.md
# Three-Source Edge Interrupt Controller

This block merges three interrupt sources into one host interrupt request. The sources are a digital port line (bit 3 of the third I/O port), an external logic-level input and the output of a timer channel. Static board-level selects decide which sources take part. One select picks either the port line or the external input as the digital source. A digital enable admits that chosen source, and a separate timer enable admits the timer source. An active-low hardware gate input can block interrupts entirely.

Each source line is first synchronized to the system clock. A rising edge on an admitted source then sets a sticky pending flag. The host controls the block through three write-only offsets, and the data written is never looked at. A write to offset 0xE turns the request output on. A write to 0xD turns it off. A write to 0xF clears the pending flag. The request output is registered and equals the pending flag ANDed with the software enable and the synchronized gate.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, the software enable is off and nothing is pending. A source edge that arrives after reset with no enable write leaves `irq_o` at 0.
- R2: A write with `wr_addr_i` = 0xE turns the enable on. From then on `irq_o` follows the pending flag, one clock after the enable register.
- R3: A write with `wr_addr_i` = 0xD turns the enable off. `irq_o` is still 1 at the edge that takes the write and is 0 after the following edge. The pending flag is kept, so a later enable write brings `irq_o` back.
- R4: A write with `wr_addr_i` = 0xF clears the pending flag, and `irq_o` falls one edge after the write edge. If a qualified source edge is captured in the same cycle as the clear, the edge wins and the flag stays set.
- R5: Only a 0-to-1 transition of a source sets the pending flag. With a `SYNC_STAGES` of 2, `irq_o` rises on the 4th clock edge after the input changes. A source held high does not set the flag again after a clear, and a falling transition never sets it.
- R6: With `sel_ext_i` = 0 the digital source is `port_bit_i` and `ext_irq_i` is ignored. With `sel_ext_i` = 1 the digital source is `ext_irq_i` and `port_bit_i` is ignored.
- R7: With `dig_en_i` = 0, edges on both digital inputs are ignored.
- R8: The timer source `tmr_out_i` sets the flag only when `tmr_en_i` = 1, whatever the value of `sel_ext_i`.
- R9: While `ext_gate_n_i` is low (after synchronization), `irq_o` is 0 and source edges are not captured. Raising the gate again restores a flag that was already pending but does not recover edges that were missed.
- R10: A write to any offset other than 0xD, 0xE and 0xF changes neither the enable nor the pending flag.
- R11: Edges captured while the enable is off stay pending and appear on `irq_o` once the enable is turned on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_bit_i | input | 1 | Digital port line source (asynchronous) |
| ext_irq_i | input | 1 | External interrupt line source (asynchronous) |
| tmr_out_i | input | 1 | Timer channel output source (asynchronous) |
| sel_ext_i | input | 1 | Static route select: 0 = port line, 1 = external line |
| dig_en_i | input | 1 | Static enable for the selected digital source |
| tmr_en_i | input | 1 | Static enable for the timer source |
| ext_gate_n_i | input | 1 | Active-low interrupt block (asynchronous) |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Host write offset |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The bench sweeps every combination of route select, digital enable and timer enable against a pulse on each of the three sources. A wrong multiplexer or an enable that leaks would raise `irq_o` for a source that should be ignored, or stay silent for one that should fire. Directed cases cover the following:
- the exact four-edge latency, and a level held high across a clear, which would re-fire if the detector were level-sensitive;
- a clear that lands in the same cycle as a new edge, where a clear-wins priority would drop an interrupt;
- the one-cycle lag of disable and clear;
- a gate that must block capture and not only mask the output;
- writes to unused offsets, which a loose address decode would turn into an enable, disable or clear.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  localparam int OFS_DISABLE = 13;
  localparam int OFS_ENABLE  = 14;
  localparam int OFS_CLEAR   = 15;

  localparam int NUM_SRC = 3;

  typedef enum int {
    SRC_PORT = 0,
    SRC_EXT  = 1,
    SRC_TMR  = 2
  } src_idx_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irq_host_ctl.sv
module irq_host_ctl
  import irq_edge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              en_o,
  output logic              clr_o
);
  logic hit_en, hit_dis;

  assign hit_en  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_ENABLE));
  assign hit_dis = wr_en_i && (wr_addr_i == ADDR_W'(OFS_DISABLE));
  assign clr_o   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CLEAR));

  always_ff @(posedge clk) begin
    if (rst)          en_o <= 1'b0;
    else if (hit_en)  en_o <= 1'b1;
    else if (hit_dis) en_o <= 1'b0;
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_edge_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_bit_i,
  input  logic              ext_irq_i,
  input  logic              tmr_out_i,
  input  logic              sel_ext_i,
  input  logic              dig_en_i,
  input  logic              tmr_en_i,
  input  logic              ext_gate_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              irq_o
);
  localparam int SYNC_W = NUM_SRC + 1;

  logic [SYNC_W-1:0]  raw_vec, sync_vec;
  logic [NUM_SRC-1:0] src_s, rise;
  logic gate_s, dig_rise, capture, clr_req, en_q, pending_q;

  assign raw_vec = {ext_gate_n_i, tmr_out_i, ext_irq_i, port_bit_i};

  irq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_vec), .q_o(sync_vec)
  );

  assign src_s  = sync_vec[NUM_SRC-1:0];
  assign gate_s = sync_vec[NUM_SRC];

  irq_rise_det #(.WIDTH(NUM_SRC)) u_rise (
    .clk(clk), .rst(rst), .lvl_i(src_s), .rise_o(rise)
  );

  irq_host_ctl #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .en_o(en_q), .clr_o(clr_req)
  );

  assign dig_rise = sel_ext_i ? rise[SRC_EXT] : rise[SRC_PORT];
  assign capture  = gate_s & ((dig_en_i & dig_rise) | (tmr_en_i & rise[SRC_TMR]));

  always_ff @(posedge clk) begin
    if (rst)          pending_q <= 1'b0;
    else if (capture) pending_q <= 1'b1;
    else if (clr_req) pending_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= pending_q & en_q & gate_s;
  end
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk
  import irq_edge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              dig_en_i,
  input logic              tmr_en_i,
  input logic              gate_s,
  input logic              capture,
  input logic              pending_q,
  input logic              en_q,
  input logic              irq_o
);
  logic w_en, w_dis, w_clr, w_other;
  assign w_en    = wr_en_i && (wr_addr_i == ADDR_W'(OFS_ENABLE));
  assign w_dis   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_DISABLE));
  assign w_clr   = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CLEAR));
  assign w_other = wr_en_i && !w_en && !w_dis && !w_clr;

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && !pending_q && !en_q)); // R1
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    w_en |=> en_q); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(pending_q)); // R2
  AST_DIS_DROP: assert property (@(posedge clk) disable iff (rst)
    w_dis |=> ##1 !irq_o); // R3
  AST_CLR_DROP: assert property (@(posedge clk) disable iff (rst)
    (w_clr && !capture) |=> !pending_q); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !w_clr) |=> pending_q); // R4
  AST_NO_SRC: assert property (@(posedge clk) disable iff (rst)
    (!dig_en_i && !tmr_en_i && !pending_q) |=> !pending_q); // R7
  AST_GATE_MASK: assert property (@(posedge clk) disable iff (rst)
    !gate_s |=> !irq_o); // R9
  AST_OTHER_OFS: assert property (@(posedge clk) disable iff (rst)
    w_other |=> (en_q == $past(en_q))); // R10
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .dig_en_i(dig_en_i), .tmr_en_i(tmr_en_i), .gate_s(gate_s),
  .capture(capture), .pending_q(pending_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/irq_edge_ctrl_tb.sv
`timescale 1ns/1ps
module irq_edge_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_bit_i = 0, ext_irq_i = 0, tmr_out_i = 0;
  logic sel_ext_i = 0, dig_en_i = 0, tmr_en_i = 0, ext_gate_n_i = 1;
  logic wr_en_i = 0;
  logic [3:0] wr_addr_i = '0;
  logic irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_edge_ctrl #(.ADDR_W(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .port_bit_i(port_bit_i), .ext_irq_i(ext_irq_i),
    .tmr_out_i(tmr_out_i), .sel_ext_i(sel_ext_i), .dig_en_i(dig_en_i),
    .tmr_en_i(tmr_en_i), .ext_gate_n_i(ext_gate_n_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .irq_o(irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    n_vec++;
    if (irq_o !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, irq_o, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a);
    wr_en_i = 1'b1;
    wr_addr_i = a;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: port_bit_i = 1'b1;
      1: ext_irq_i  = 1'b1;
      default: tmr_out_i = 1'b1;
    endcase
    step(6);
    port_bit_i = 1'b0;
    ext_irq_i  = 1'b0;
    tmr_out_i  = 1'b0;
    step(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: irq_o=%0b expected run end", irq_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    check("R1 reset value", 1'b0);

    // R1 / R11: edge after reset is held but not requested until enable
    dig_en_i = 1'b1;
    sel_ext_i = 1'b0;
    pulse(0);
    check("R1 no request while disabled after reset", 1'b0);
    wr(4'hE);
    step(1);
    check("R11 pending edge shows on enable", 1'b1);

    // R4: clear timing
    wr(4'hF);
    check("R4 irq still high at clear edge", 1'b1);
    step(1);
    check("R4 irq low one edge after clear", 1'b0);

    // R5: latency and level/falling behaviour
    port_bit_i = 1'b1;
    step(3);
    check("R5 no request after three edges", 1'b0);
    step(1);
    check("R5 request on fourth edge", 1'b1);
    step(10);
    wr(4'hF);
    step(3);
    check("R5 held level does not re-fire", 1'b0);
    port_bit_i = 1'b0;
    step(6);
    check("R5 falling transition ignored", 1'b0);

    // R3: disable timing, pending kept
    pulse(0);
    check("R3 pending before disable", 1'b1);
    wr(4'hD);
    check("R3 irq still high at disable edge", 1'b1);
    step(1);
    check("R3 irq low after disable", 1'b0);
    wr(4'hE);
    step(1);
    check("R3 pending kept through disable", 1'b1);

    // R4: clear and edge in the same cycle, edge wins
    port_bit_i = 1'b1;
    step(2);
    wr_en_i = 1'b1;
    wr_addr_i = 4'hF;
    step(1);
    wr_en_i = 1'b0;
    step(2);
    check("R4 simultaneous edge beats clear", 1'b1);
    port_bit_i = 1'b0;
    step(6);

    // R6 R7 R8: sweep of routing and enables against each source
    for (int s = 0; s < 2; s++) begin
      for (int de = 0; de < 2; de++) begin
        for (int te = 0; te < 2; te++) begin
          for (int src = 0; src < 3; src++) begin
            logic exp;
            sel_ext_i = s[0];
            dig_en_i  = de[0];
            tmr_en_i  = te[0];
            step(2);
            wr(4'hF);
            step(3);
            check("R4 sweep clear", 1'b0);
            pulse(src);
            if (src == 2) exp = te[0];
            else exp = de[0] && ((src == 0) ? !s[0] : s[0]);
            if (src == 2) check("R8 timer source gating", exp);
            else if (de == 0) check("R7 digital enable off", exp);
            else check("R6 route select", exp);
          end
        end
      end
    end

    // R9: gate masks output and blocks capture
    sel_ext_i = 1'b0;
    dig_en_i = 1'b1;
    tmr_en_i = 1'b0;
    wr(4'hF);
    step(2);
    pulse(0);
    check("R9 request before gate", 1'b1);
    ext_gate_n_i = 1'b0;
    step(4);
    check("R9 gate low masks request", 1'b0);
    ext_gate_n_i = 1'b1;
    step(4);
    check("R9 pending restored after gate", 1'b1);
    wr(4'hF);
    step(3);
    ext_gate_n_i = 1'b0;
    step(4);
    pulse(0);
    ext_gate_n_i = 1'b1;
    step(4);
    check("R9 edge during gate not captured", 1'b0);

    // R10: other offsets have no effect
    pulse(0);
    check("R10 request before stray writes", 1'b1);
    for (int a = 0; a < 13; a++) begin
      wr(4'(a));
      step(2);
      check("R10 stray write while enabled", 1'b1);
    end
    wr(4'hD);
    step(2);
    for (int a = 0; a < 13; a++) begin
      wr(4'(a));
      step(2);
      check("R10 stray write while disabled", 1'b0);
    end
    wr(4'hE);
    step(2);
    check("R10 pending survived stray writes", 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule